// File: doc/BRIEF.md
# Flash Status Register with Sticky Fail Flags

This block holds the eight-bit status word of a parallel NOR-style flash controller. The command decoder and the internal write engine give it single-cycle pulses: operation start and finish, suspend and resume, failures, abort, sleep, status clear and the return to array reads. From these it keeps a ready flag, an erase-suspended flag, two sticky fail flags and a sleep flag. A sector-protect bit follows the two end-sector protect inputs directly.

The host reads the word over an asynchronous chip-enable and output-enable pair. Both strobes are first brought into the clock domain. When both are seen low, the word is copied into a snapshot register. The copy stays frozen until the host deselects and selects again, so a value that changes in the middle of a cycle cannot reach the bus. The output stage places the snapshot on the low data byte. In word mode it also drives the upper byte as zero. In byte mode it leaves the upper byte undriven.

The block also produces a pull-down enable for an open-drain ready/busy line. Deep power-down forces the register to its default value and disables the data outputs.

Top module: `nor_status_reg`

## Requirements
- R1: After reset the status word reads 80h (bit3 follows the protect inputs, which are low in that case). Bits 1:0 of the data bus always read 0.
- R2: A start pulse clears bit7, the ready bit, where 0 means busy. A done pulse sets bit7 and clears bit6.
- R3: A suspend request sets bit6 only while bit7 is 0; while bit7 is 1 it is ignored. A suspend-reached pulse sets bit7 only while bit6 is 1. A resume pulse clears both bit6 and bit7 when bit6 is 1, and has no effect when bit6 is 0.
- R4: The engine fail pulses set bit5 (erase fail) and bit4 (program fail). Nothing except the clear-status pulse clears these bits. When a fail pulse and a clear-status pulse arrive in the same cycle, the bit ends up set.
- R5: An abort pulse sets bit2 and bit7 and clears bit6. It also sets bit5 when abort_is_erase is 1, and sets bit4 when abort_is_erase is 0.
- R6: A sleep pulse sets bit2. Only the read-array pulse clears bit2; clear-status leaves it unchanged.
- R7: Bit3 is the OR of prot_lo and prot_hi at all times. No pulse writes it.
- R8: The bus value is captured when both ce_n and oe_n are seen low after SYNC_STAGES clocks of synchronization. The captured value does not change while both strobes stay low, even if the flags change.
- R9: Data outputs are enabled only while the device is selected and pwd_n is high. In word mode (byte_mode=0) dq_oe_hi is 1 and dq_out[15:8] is 00h. In byte mode (byte_mode=1) dq_oe_hi is 0.
- R10: While pwd_n is low, the register is held at its default value (bits 7:4 = 1000, bit2 = 0), all pulses are ignored, and the data outputs are disabled.
- R11: ry_pull is 1 (line driven low) only when bit7 is 0, bit6 is 0 and pwd_n is high. ce_n and oe_n have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwd_n | input | 1 | Deep power-down, active low |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| eng_start | input | 1 | Engine began an operation |
| eng_done | input | 1 | Engine finished an operation |
| susp_req | input | 1 | Erase suspend command |
| susp_reached | input | 1 | Engine reached its suspended state |
| resume_cmd | input | 1 | Erase resume command |
| erase_fail | input | 1 | Engine reports an erase failure |
| prog_fail | input | 1 | Engine reports a program failure |
| abort_evt | input | 1 | Abort of the running operation |
| abort_is_erase | input | 1 | Aborted operation was an erase |
| sleep_evt | input | 1 | Sleep mode entered |
| rd_array_cmd | input | 1 | Read-array command |
| clr_status_cmd | input | 1 | Clear-status command |
| prot_lo | input | 1 | Bottom sector protected |
| prot_hi | input | 1 | Top sector protected |
| dq_out | output | DQ_W | Data bus output value |
| dq_oe_lo | output | 1 | Drive enable for dq_out[7:0] |
| dq_oe_hi | output | 1 | Drive enable for the upper byte |
| ry_pull | output | 1 | Pull the ready/busy line low |

## Verification
Two collisions are tested. In the first, the engine sets a fail flag in the same cycle that the host clears the status. The bench pulses erase_fail and clr_status_cmd on the same clock, then pulses prog_fail and clr_status_cmd on another clock. A fresh read must show each flag set. In the second, a flag changes while a read cycle is open. The bench pulses eng_start while both strobes are held low. It requires the bus value to stay unchanged while ry_pull goes high at once. After the host toggles the strobes, the next read must show the new value.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned B_READY  = 7;
  localparam int unsigned B_SUSP   = 6;
  localparam int unsigned B_EFAIL  = 5;
  localparam int unsigned B_PFAIL  = 4;
  localparam int unsigned B_PROT   = 3;
  localparam int unsigned B_SLEEP  = 2;

  typedef struct packed {
    logic ready;
    logic susp;
    logic efail;
    logic pfail;
    logic sleep;
  } nsr_flags_t;

  localparam nsr_flags_t FLAGS_DEFAULT = '{ready: 1'b1, susp: 1'b0,
                                           efail: 1'b0, pfail: 1'b0,
                                           sleep: 1'b0};

  function automatic logic [STAT_W-1:0] pack_status(nsr_flags_t f, logic prot);
    logic [STAT_W-1:0] s;
    s          = '0;
    s[B_READY] = f.ready;
    s[B_SUSP]  = f.susp;
    s[B_EFAIL] = f.efail;
    s[B_PFAIL] = f.pfail;
    s[B_PROT]  = prot;
    s[B_SLEEP] = f.sleep;
    return s;
  endfunction
endpackage

// File: rtl/nsr_sync.sv
module nsr_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= '1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nsr_flags.sv
module nsr_flags
  import nsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwd_n,
  input  logic       eng_start,
  input  logic       eng_done,
  input  logic       susp_req,
  input  logic       susp_reached,
  input  logic       resume_cmd,
  input  logic       erase_fail,
  input  logic       prog_fail,
  input  logic       abort_evt,
  input  logic       abort_is_erase,
  input  logic       sleep_evt,
  input  logic       rd_array_cmd,
  input  logic       clr_status_cmd,
  output nsr_flags_t flags
);
  nsr_flags_t cur, nxt;
  logic susp_ok, resume_ok, reach_ok;

  assign susp_ok   = susp_req & ~cur.ready & ~cur.susp;
  assign resume_ok = resume_cmd & cur.susp;
  assign reach_ok  = susp_reached & cur.susp;

  always_comb begin
    nxt = cur;
    // ready: clears lose against sets
    if (eng_start || resume_ok)              nxt.ready = 1'b0;
    if (eng_done || reach_ok || abort_evt)   nxt.ready = 1'b1;
    // suspend
    if (resume_ok || eng_done || abort_evt)  nxt.susp = 1'b0;
    if (susp_ok)                             nxt.susp = 1'b1;
    // sticky fail flags: engine sets, only host clears, set wins
    if (clr_status_cmd) begin
      nxt.efail = 1'b0;
      nxt.pfail = 1'b0;
    end
    if (erase_fail || (abort_evt && abort_is_erase))  nxt.efail = 1'b1;
    if (prog_fail  || (abort_evt && !abort_is_erase)) nxt.pfail = 1'b1;
    // sleep
    if (rd_array_cmd)                        nxt.sleep = 1'b0;
    if (sleep_evt || abort_evt)              nxt.sleep = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cur <= FLAGS_DEFAULT;
    else if (!pwd_n) cur <= FLAGS_DEFAULT;
    else             cur <= nxt;
  end

  assign flags = cur;

  // R4
  efail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.efail && !clr_status_cmd && pwd_n) |=> cur.efail);
  // R4
  pfail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.pfail && !clr_status_cmd && pwd_n) |=> cur.pfail);
  // R10
  pd_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwd_n |=> (cur.ready && !cur.susp && !cur.efail && !cur.pfail && !cur.sleep));
  // R3
  susp_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur.susp) |-> !$past(cur.ready));
endmodule

// File: rtl/nsr_rdsnap.sv
module nsr_rdsnap
  import nsr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [STAT_W-1:0] live_stat,
  output logic              sel,
  output logic [STAT_W-1:0] snap
);
  logic [1:0] strobes_s;
  logic       sel_d;
  logic       capture;

  nsr_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({ce_n, oe_n}),
    .q_sync  (strobes_s)
  );

  assign sel     = ~strobes_s[1] & ~strobes_s[0];
  assign capture = sel & ~sel_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_d <= 1'b0;
      snap  <= '0;
    end else begin
      sel_d <= sel;
      if (capture) snap <= live_stat;
    end
  end

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sel_d) |=> $stable(snap));
endmodule

// File: rtl/nsr_fmt.sv
module nsr_fmt
  import nsr_pkg::*;
#(
  parameter int unsigned DQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              pwd_n,
  input  logic              byte_mode,
  input  logic [STAT_W-1:0] snap,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe_lo,
  output logic              dq_oe_hi
);
  localparam int unsigned HI_W = DQ_W - STAT_W;

  logic drive;
  assign drive = sel & pwd_n;

  always_comb begin
    dq_out                = '0;
    dq_out[STAT_W-1:2]    = snap[STAT_W-1:2];
    dq_out[DQ_W-1:STAT_W] = {HI_W{1'b0}};
  end

  assign dq_oe_lo = drive;
  assign dq_oe_hi = drive & ~byte_mode;

  // R9
  byte_hi_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> !dq_oe_hi);
  // R10
  pd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwd_n |-> (!dq_oe_lo && !dq_oe_hi));
  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_lo |-> (dq_out[1:0] == 2'b00));
endmodule

// File: rtl/nor_status_reg.sv
module nor_status_reg
  import nsr_pkg::*;
#(
  parameter int unsigned DQ_W        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwd_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            byte_mode,
  input  logic            eng_start,
  input  logic            eng_done,
  input  logic            susp_req,
  input  logic            susp_reached,
  input  logic            resume_cmd,
  input  logic            erase_fail,
  input  logic            prog_fail,
  input  logic            abort_evt,
  input  logic            abort_is_erase,
  input  logic            sleep_evt,
  input  logic            rd_array_cmd,
  input  logic            clr_status_cmd,
  input  logic            prot_lo,
  input  logic            prot_hi,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe_lo,
  output logic            dq_oe_hi,
  output logic            ry_pull
);
  nsr_flags_t        flags;
  logic [STAT_W-1:0] live_stat;
  logic [STAT_W-1:0] snap;
  logic              sel;
  logic              prot_any;

  assign prot_any  = prot_lo | prot_hi;
  assign live_stat = pack_status(flags, prot_any);

  nsr_flags u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwd_n          (pwd_n),
    .eng_start      (eng_start),
    .eng_done       (eng_done),
    .susp_req       (susp_req),
    .susp_reached   (susp_reached),
    .resume_cmd     (resume_cmd),
    .erase_fail     (erase_fail),
    .prog_fail      (prog_fail),
    .abort_evt      (abort_evt),
    .abort_is_erase (abort_is_erase),
    .sleep_evt      (sleep_evt),
    .rd_array_cmd   (rd_array_cmd),
    .clr_status_cmd (clr_status_cmd),
    .flags          (flags)
  );

  nsr_rdsnap #(.SYNC_STAGES(SYNC_STAGES)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .live_stat (live_stat),
    .sel       (sel),
    .snap      (snap)
  );

  nsr_fmt #(.DQ_W(DQ_W)) u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .pwd_n     (pwd_n),
    .byte_mode (byte_mode),
    .snap      (snap),
    .dq_out    (dq_out),
    .dq_oe_lo  (dq_oe_lo),
    .dq_oe_hi  (dq_oe_hi)
  );

  assign ry_pull = ~flags.ready & ~flags.susp & pwd_n;

  // R11
  pd_ry_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwd_n |-> !ry_pull);
  // R11
  suspended_ry_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_stat[B_SUSP] |-> !ry_pull);
endmodule

// File: tb/test_nor_status_reg.sv
module test_nor_status_reg;
  localparam int DQ_W = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwd_n = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, byte_mode = 1'b0;
  logic eng_start = 0, eng_done = 0, susp_req = 0, susp_reached = 0;
  logic resume_cmd = 0, erase_fail = 0, prog_fail = 0, abort_evt = 0;
  logic abort_is_erase = 0, sleep_evt = 0, rd_array_cmd = 0, clr_status_cmd = 0;
  logic prot_lo = 0, prot_hi = 0;
  logic [DQ_W-1:0] dq_out;
  logic dq_oe_lo, dq_oe_hi, ry_pull;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nor_status_reg #(.DQ_W(DQ_W), .SYNC_STAGES(SYNC)) i_nor_status_reg (
    .clk(clk), .rst_n(rst_n), .pwd_n(pwd_n), .ce_n(ce_n), .oe_n(oe_n),
    .byte_mode(byte_mode), .eng_start(eng_start), .eng_done(eng_done),
    .susp_req(susp_req), .susp_reached(susp_reached), .resume_cmd(resume_cmd),
    .erase_fail(erase_fail), .prog_fail(prog_fail), .abort_evt(abort_evt),
    .abort_is_erase(abort_is_erase), .sleep_evt(sleep_evt),
    .rd_array_cmd(rd_array_cmd), .clr_status_cmd(clr_status_cmd),
    .prot_lo(prot_lo), .prot_hi(prot_hi), .dq_out(dq_out),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .ry_pull(ry_pull));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pulse codes: 0 start 1 done 2 susp 3 reached 4 resume 5 efail 6 pfail
  // 7 abort 8 sleep 9 rdarray 10 clr
  task automatic set_ev(input int code, input logic v);
    case (code)
      0: eng_start = v;       1: eng_done = v;     2: susp_req = v;
      3: susp_reached = v;    4: resume_cmd = v;   5: erase_fail = v;
      6: prog_fail = v;       7: abort_evt = v;    8: sleep_evt = v;
      9: rd_array_cmd = v;    10: clr_status_cmd = v;
      default: ;
    endcase
  endtask

  task automatic pulse(input int code);
    @(negedge clk); set_ev(code, 1'b1);
    @(negedge clk); set_ev(code, 1'b0);
  endtask

  task automatic pulse2(input int a, input int b);
    @(negedge clk); set_ev(a, 1'b1); set_ev(b, 1'b1);
    @(negedge clk); set_ev(a, 1'b0); set_ev(b, 1'b0);
  endtask

  task automatic open_read();
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic close_read();
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic read_stat(output logic [15:0] v);
    open_read();
    v = dq_out;
    close_read();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    open_read();
    check("R1 reset word", {16'h0, dq_out}, 32'h0080);
    check("R9 word hi enabled", dq_oe_hi, 1);
    check("R9 lo enabled", dq_oe_lo, 1);
    close_read();
    check("R9 deselected no drive", dq_oe_lo, 0);
    check("R11 reset ry_pull", ry_pull, 0);
    read_stat(v);
    check("R1 bits 1:0", v[1:0], 0);
  endtask

  task automatic t_ready();
    logic [15:0] v;
    pulse(0);
    check("R11 busy pulls", ry_pull, 1);
    read_stat(v);
    check("R2 busy", v, 16'h0000);
    pulse(1);
    check("R11 ready releases", ry_pull, 0);
    read_stat(v);
    check("R2 done", v, 16'h0080);
  endtask

  task automatic t_suspend();
    logic [15:0] v;
    pulse(2);
    read_stat(v);
    check("R3 susp ignored when ready", v, 16'h0080);
    pulse(4);
    read_stat(v);
    check("R3 resume ignored", v, 16'h0080);
    pulse(0);
    pulse(3);
    read_stat(v);
    check("R3 reached ignored unsuspended", v, 16'h0000);
    pulse(2);
    check("R11 suspended releases", ry_pull, 0);
    read_stat(v);
    check("R3 suspend pending", v, 16'h0040);
    pulse(3);
    read_stat(v);
    check("R3 suspend reached", v, 16'h00C0);
    pulse(4);
    check("R11 resumed busy", ry_pull, 1);
    read_stat(v);
    check("R3 resumed", v, 16'h0000);
    pulse(1);
    read_stat(v);
    check("R2 done after resume", v, 16'h0080);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    pulse(5);
    pulse(0); pulse(1);
    read_stat(v);
    check("R4 efail survives engine", v, 16'h00A0);
    pulse(9);
    read_stat(v);
    check("R4 rdarray keeps efail", v, 16'h00A0);
    pulse2(6, 10);
    read_stat(v);
    check("R4 pfail set wins clear", v, 16'h0090);
    pulse2(5, 10);
    read_stat(v);
    check("R4 efail set wins clear", v, 16'h00A0);
    pulse(10);
    read_stat(v);
    check("R4 clear", v, 16'h0080);
  endtask

  task automatic t_abort_sleep();
    logic [15:0] v;
    pulse(0);
    @(negedge clk); abort_is_erase = 1'b1;
    pulse(7);
    read_stat(v);
    check("R5 erase abort", v, 16'h00A4);
    pulse(10);
    pulse(0);
    @(negedge clk); abort_is_erase = 1'b0;
    pulse(7);
    read_stat(v);
    check("R5 program abort", v, 16'h0094);
    pulse(10);
    read_stat(v);
    check("R6 clr keeps sleep", v, 16'h0084);
    pulse(9);
    read_stat(v);
    check("R6 rdarray clears sleep", v, 16'h0080);
    pulse(8);
    read_stat(v);
    check("R6 sleep sets", v, 16'h0084);
    pulse(9);
  endtask

  task automatic t_prot();
    logic [15:0] v;
    @(negedge clk); prot_lo = 1'b1;
    read_stat(v);
    check("R7 prot_lo", v, 16'h0088);
    pulse(10);
    read_stat(v);
    check("R7 clr no effect", v, 16'h0088);
    @(negedge clk); prot_lo = 1'b0; prot_hi = 1'b1;
    read_stat(v);
    check("R7 prot_hi", v, 16'h0088);
    @(negedge clk); prot_hi = 1'b0;
    read_stat(v);
    check("R7 none", v, 16'h0080);
  endtask

  task automatic t_snapshot();
    logic [15:0] v1, v2, v3;
    open_read();
    v1 = dq_out;
    pulse(0);
    repeat (3) @(negedge clk);
    v2 = dq_out;
    check("R11 ry_pull while selected", ry_pull, 1);
    check("R8 held during read", v2, v1);
    check("R8 first value", v1, 16'h0080);
    close_read();
    read_stat(v3);
    check("R8 new read", v3, 16'h0000);
    pulse(1);
  endtask

  task automatic t_byte();
    @(negedge clk); byte_mode = 1'b1;
    open_read();
    check("R9 byte hi floats", dq_oe_hi, 0);
    check("R9 byte lo value", dq_out[7:0], 8'h80);
    close_read();
    @(negedge clk); byte_mode = 1'b0;
  endtask

  task automatic t_pd();
    logic [15:0] v;
    pulse(0); pulse(5); pulse(8);
    @(negedge clk); pwd_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 ry released", ry_pull, 0);
    pulse(6);
    pulse(0);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
    repeat (SYNC + 3) @(negedge clk);
    check("R10 lo off", dq_oe_lo, 0);
    check("R10 hi off", dq_oe_hi, 0);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    @(negedge clk); pwd_n = 1'b1;
    read_stat(v);
    check("R10 default after pd", v, 16'h0080);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ready();
    t_suspend();
    t_sticky();
    t_abort_sleep();
    t_prot();
    t_snapshot();
    t_byte();
    t_pd();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule